// File: doc/BRIEF.md
# Leading Match Counter

This unit answers two related questions about a 32-bit word with a single counter. In scan mode it walks from the most significant bit downward and reports how many positions it passes before reaching a bit equal to a chosen polarity. Bit 0 of a separate selector word chooses that polarity. In normalize mode it treats the word as a two's-complement value and reports how many bits below the sign bit repeat the sign before the first bit that differs from it. That count is the left shift that brings the value to normalized form.

A request is presented with `in_valid`, an opcode, the selector and the data word. One clock later the count appears on `out_count` together with `out_valid`. The count register keeps its value between requests.

Top module: `lead_count_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0 and `out_count` = 0.
- R2: `out_valid` is high in the cycle after a clock edge with `in_valid` high, and low in the cycle after an edge with `in_valid` low.
- R3: With `in_op` = 0 (scan mode) and `in_sel[0]` = 1, the count is the number of zero bits above the highest one bit (0x00005454 gives 17).
- R4: With `in_op` = 0 and `in_sel[0]` = 0, the count is the number of one bits above the highest zero bit (0xFFFFFFEE gives 27).
- R5: In scan mode, a word with no bit equal to the selected polarity gives 32.
- R6: In scan mode only `in_sel[0]` affects the result. Bits 31..1 of the selector have no effect.
- R7: With `in_op` = 1 (normalize mode), the count is the number of bits from bit 30 downward that equal bit 31 before the first bit that differs (0x0000FFFF gives 15, 0x00005454 gives 16, 0x00003333 gives 17, 0x00000003 gives 29).
- R8: In normalize mode, a word whose bits all equal (0x00000000 or 0xFFFFFFFF) gives 31.
- R9: In normalize mode the selector has no effect on the result.
- R10: At a clock edge with `in_valid` low, `out_count` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = scan for polarity, 1 = normalize |
| in_sel | input | 32 | Selector; bit 0 is the scan polarity |
| in_data | input | 32 | Operand word |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_count | output | 6 | Registered count, 0 to 32 |

## Verification
Every result is due exactly one clock edge after the request edge, because only one register stage lies between the inputs and `out_count`. The bench changes inputs on the falling edge. It samples the outputs one nanosecond after the next rising edge, so each sample sees the result of the request applied just before that edge. A behavioural model updates its expected count at that same edge only when `in_valid` is high, and holds it otherwise. Checking every cycle against this model therefore also covers the hold behaviour and the valid timing.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  typedef enum logic [0:0] {
    OP_SCAN = 1'b0,
    OP_NORM = 1'b1
  } lcu_op_e;
endpackage

// File: rtl/lcu_hit_vec.sv
// Builds a vector whose highest set bit marks where counting stops.
module lcu_hit_vec
  import lcu_pkg::*;
#(
  parameter int W = 32
) (
  input  lcu_op_e        op,
  input  logic           pol,
  input  logic [W-1:0]   data,
  output logic [W-1:0]   hit
);
  logic [W-1:0] scan_hit;
  logic [W-1:0] norm_hit;

  // Normalize mode: bit i of the vector flags data[i-1] differing from the sign.
  // Bit 0 is a fixed stop, so a word whose bits all equal yields W-1.
  assign norm_hit[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign scan_hit[i] = (data[i] == pol);
  end

  for (genvar i = 1; i < W; i++) begin : g_norm
    assign norm_hit[i] = data[i-1] ^ data[W-1];
  end

  assign hit = (op == OP_NORM) ? norm_hit : scan_hit;
endmodule

// File: rtl/lcu_lead_count.sv
// Counts the zero bits above the highest set bit; W when none is set.
module lcu_lead_count #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/lead_count_unit.sv
module lead_count_unit
  import lcu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_op,
  input  logic [W-1:0]  in_sel,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [CW-1:0] out_count
);
  lcu_op_e       op;
  logic [W-1:0]  hit;
  logic [CW-1:0] cnt_d;
  logic          unused_sel_hi;

  assign op            = lcu_op_e'(in_op);
  assign unused_sel_hi = ^in_sel[W-1:1];

  lcu_hit_vec #(.W(W)) u_hit (
    .op   (op),
    .pol  (in_sel[0]),
    .data (in_data),
    .hit  (hit)
  );

  lcu_lead_count #(.W(W), .CW(CW)) u_cnt (
    .vec (hit),
    .cnt (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_count <= cnt_d;
    end
  end
endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_op,
  input logic          sel0,
  input logic [1:0]    top2,
  input logic          out_valid,
  input logic [CW-1:0] out_count
);
  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_count));
  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count <= CW'(W)));
  // R8
  norm_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op) |=> (out_count <= CW'(W - 1)));
  // R3
  scan_top_match_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op && (sel0 == top2[1])) |=> (out_count == '0));
  // R7
  norm_top_differ_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op && (top2[1] != top2[0])) |=> (out_count == '0));
endmodule

bind lead_count_unit lcu_checker #(.W(W), .CW(CW)) u_lcu_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .sel0      (in_sel[0]),
  .top2      (in_data[W-1:W-2]),
  .out_valid (out_valid),
  .out_count (out_count)
);

// File: tb/lead_count_unit_bench.sv
`timescale 1ns/1ps
module lead_count_unit_bench;
  localparam int W  = 32;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_op;
  logic [W-1:0]  in_sel;
  logic [W-1:0]  in_data;
  logic          out_valid;
  logic [CW-1:0] out_count;

  int tests = 0;
  int fails = 0;
  int exp_count = 0;
  bit exp_valid = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lead_count_unit #(.W(W), .CW(CW)) u_lead_count_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_sel(in_sel), .in_data(in_data),
    .out_valid(out_valid), .out_count(out_count)
  );

  function automatic int model(bit op, logic [W-1:0] sel, logic [W-1:0] d);
    int n = 0;
    if (!op) begin
      for (int i = W - 1; i >= 0; i--) begin
        if (d[i] == sel[0]) return n;
        n++;
      end
      return W;
    end
    for (int i = W - 2; i >= 0; i--) begin
      if (d[i] != d[W-1]) return n;
      n++;
    end
    return W - 1;
  endfunction

  task automatic check(string req);
    tests++;
    if (out_valid !== exp_valid || out_count !== CW'(exp_count)) begin
      fails++;
      $display("FAIL %s: got valid=%0b count=%0d, expected valid=%0b count=%0d",
               req, out_valid, out_count, exp_valid, exp_count);
    end
  endtask

  task automatic step(bit v, bit op, logic [W-1:0] sel, logic [W-1:0] d,
                      string req, int want = -1);
    @(negedge clk);
    in_valid = v; in_op = op; in_sel = sel; in_data = d;
    @(posedge clk);
    exp_valid = v;
    if (v) exp_count = model(op, sel, d);
    #1;
    check(req);
    if (want >= 0 && v) begin
      tests++;
      if (out_count !== CW'(want)) begin
        fails++;
        $display("FAIL %s: got count=%0d, expected %0d", req, out_count, want);
      end
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_op = 1'b0; in_sel = '0; in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    exp_valid = 0; exp_count = 0;
    check("R1 reset");
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    // R3 / R4 scan examples
    step(1, 0, 32'h0000_5151, 32'h0000_5454, "R3 scan ones", 17);
    step(1, 0, 32'h0000_0000, 32'hFFFF_FFEE, "R4 scan zeros", 27);
    step(1, 0, 32'h1, 32'h8000_0000, "R3 top bit", 0);
    step(1, 0, 32'h1, 32'h0000_0001, "R3 lsb only", 31);
    // R5 no match
    step(1, 0, 32'h1, 32'h0000_0000, "R5 no one", 32);
    step(1, 0, 32'h0, 32'hFFFF_FFFF, "R5 no zero", 32);
    // R6 upper selector bits ignored
    step(1, 0, 32'hFFFF_FFFE, 32'hFFFF_FFEE, "R6 sel hi ones", 27);
    step(1, 0, 32'h0000_0001, 32'h0000_5454, "R6 sel hi zeros", 17);
    // R7 normalize
    step(1, 1, 32'h0, 32'h0000_FFFF, "R7 norm ffff", 15);
    step(1, 1, 32'h0, 32'h0000_5454, "R7 norm 5454", 16);
    step(1, 1, 32'h0, 32'h0000_3333, "R7 norm 3333", 17);
    step(1, 1, 32'h0, 32'h0000_0003, "R7 norm 3", 29);
    step(1, 1, 32'h0, 32'hBFFF_FFFF, "R7 norm differ", 0);
    // R8 uniform words
    step(1, 1, 32'h0, 32'hFFFF_FFFF, "R8 all ones", 31);
    step(1, 1, 32'h0, 32'h0000_0000, "R8 all zeros", 31);
    // R9 selector ignored in normalize
    step(1, 1, 32'hFFFF_FFFF, 32'h0000_3333, "R9 sel ones", 17);
    // R10 hold while idle, R2 valid timing
    step(0, 0, 32'h1, 32'h0000_0001, "R10 idle hold");
    step(0, 1, 32'h0, 32'h0000_0000, "R2 idle valid low");
    step(1, 0, 32'h1, 32'h0000_0100, "R2 valid back", 23);

    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] d;
      d = $urandom();
      d = d >> ($urandom() % W);
      if ($urandom() % 2) d = ~d;
      step(bit'($urandom() % 4 != 0), bit'($urandom() % 2), $urandom(), d,
           "R3 R4 R7 R10 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule